// File: doc/BRIEF.md
# Six-Slot Statically Scheduled Issue and Writeback Pipeline

This block accepts one wide bundle of six operations per clock and retires each operation's result at a fixed, slot-dependent cycle count later. The bundle has two integer slots, two load/store slots and two floating-point slots, in that fixed order. Every slot reads its sources from one shared register file. The results pass down per-slot delay lines and are written back when the slot's latency has run out.

The hardware never checks dependencies and never stalls. The compiler must place consumers after their producers' latency. An operand read early returns the old register contents, and this is intended behaviour.

Load/store slots address a small word-organised data memory held inside the block. The floating-point slots use a wrapping integer add in place of real floating-point arithmetic. A combinational debug port reads any register.

Top module: `vliw_issue_core`

## Requirements
- R1: The bundle is 192 bits. Slot s occupies bits [32s+31:32s]: slots 0 and 1 are integer, slots 2 and 3 are load/store, slots 4 and 5 are floating-point. Each slot word has the fields opcode [31:28], rd [27:24], rs1 [23:20], rs2 [19:16] and signed imm [15:0].
- R2: Integer opcodes are 1 = rd←rs1+rs2, 2 = rd←rs1−rs2, 3 = rd←rs1+sext(imm) and 4 = rd←rs1^rs2. The result is visible to the bundle issued one cycle later.
- R3: Load/store opcodes are 1 = load, rd←mem[(rs1+sext(imm)) mod 16], and 2 = store, mem[(rs1+sext(imm)) mod 16]←rs2. Both take effect three cycles after issue. A bundle issued two cycles after a load still sees the old rd.
- R4: Floating-point opcode 1 is rd←rs1+rs2, wrapping. The result is visible to the bundle issued four cycles later and not to the one issued three cycles later.
- R5: All six slots of a bundle read register state as it stood before that bundle issued. A write made by one slot is not seen by another slot of the same bundle.
- R6: A bundle is accepted on every cycle that bundle_valid is high. A source read before its producer's latency has elapsed returns the stale value.
- R7: Opcode 0 (NOP) and any opcode not defined for the slot's class perform no register or memory write.
- R8: Register 0 always reads zero, even after a write to it.
- R9: When two writebacks reach the same register in one cycle, the higher-numbered slot wins. The same rule applies to two stores to the same word in one cycle.
- R10: A load and a store that complete in the same cycle at the same address give the load the value from before the store.
- R11: Reset clears all registers, all memory words and every in-flight operation.
- R12: A bundle presented while bundle_valid is low has no effect.
- R13: dbg_data shows register dbg_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bundle_valid | input | 1 | Bundle present this cycle |
| bundle | input | 192 | Six packed slot words |
| dbg_addr | input | 4 | Debug register index |
| dbg_data | output | 32 | Debug register contents |

## Verification
The bench makes two events meet in one cycle and checks the result at the debug port. First, a store and a load to the same word are issued in the same bundle, so both complete on the same edge; the load must return the old word. Second, a floating-point write is issued and an integer write to the same register follows three cycles later, so both retire on the same edge; the floating-point value must win. Two stores to the same word in one bundle are then read back to confirm which slot wins.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  parameter int XLEN      = 32;
  parameter int NREG      = 16;
  parameter int RAW       = $clog2(NREG);
  parameter int NSLOT     = 6;
  parameter int SLOTW     = 32;
  parameter int OPW       = 4;
  parameter int IMMW      = 16;
  parameter int MEM_WORDS = 16;
  parameter int MAW       = $clog2(MEM_WORDS);
  parameter int LAT_INT   = 1;
  parameter int LAT_MEM   = 3;
  parameter int LAT_FP    = 4;

  localparam int CL_INT = 0;
  localparam int CL_MEM = 1;
  localparam int CL_FP  = 2;

  localparam logic [OPW-1:0] OP_NOP  = 4'd0;
  localparam logic [OPW-1:0] OP_ADD  = 4'd1;
  localparam logic [OPW-1:0] OP_SUB  = 4'd2;
  localparam logic [OPW-1:0] OP_ADDI = 4'd3;
  localparam logic [OPW-1:0] OP_XOR  = 4'd4;
  localparam logic [OPW-1:0] OP_LD   = 4'd1;
  localparam logic [OPW-1:0] OP_ST   = 4'd2;
  localparam logic [OPW-1:0] OP_FADD = 4'd1;

  typedef struct packed {
    logic            wr;
    logic            ld;
    logic            st;
    logic [RAW-1:0]  rd;
    logic [XLEN-1:0] val;
    logic [MAW-1:0]  addr;
  } flight_t;

  function automatic int slot_class(input int s);
    if (s < 2) return CL_INT;
    else if (s < 4) return CL_MEM;
    else return CL_FP;
  endfunction

  function automatic int slot_lat(input int s);
    if (s < 2) return LAT_INT;
    else if (s < 4) return LAT_MEM;
    else return LAT_FP;
  endfunction
endpackage

// File: rtl/vliw_slot_exec.sv
module vliw_slot_exec
  import vliw_pkg::*;
#(
  parameter int CLASS = CL_INT
) (
  input  logic             valid,
  input  logic [SLOTW-1:0] word,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output flight_t          res
);
  logic [OPW-1:0]  op;
  logic [XLEN-1:0] simm;
  logic [XLEN-1:0] ea;

  assign op   = word[31:28];
  assign simm = {{(XLEN-IMMW){word[IMMW-1]}}, word[IMMW-1:0]};
  assign ea   = a + simm;

  always_comb begin
    res      = '0;
    res.rd   = word[27:24];
    res.addr = ea[MAW-1:0];
    if (CLASS == CL_INT) begin
      case (op)
        OP_ADD:  begin res.wr = 1'b1; res.val = a + b;    end
        OP_SUB:  begin res.wr = 1'b1; res.val = a - b;    end
        OP_ADDI: begin res.wr = 1'b1; res.val = ea;       end
        OP_XOR:  begin res.wr = 1'b1; res.val = a ^ b;    end
        default: ;
      endcase
    end else if (CLASS == CL_MEM) begin
      case (op)
        OP_LD:   begin res.wr = 1'b1; res.ld = 1'b1;      end
        OP_ST:   begin res.st = 1'b1; res.val = b;        end
        default: ;
      endcase
    end else begin
      if (op == OP_FADD) begin
        res.wr  = 1'b1;
        res.val = a + b;
      end
    end
    if (!valid) begin
      res.wr = 1'b0;
      res.ld = 1'b0;
      res.st = 1'b0;
    end
  end
endmodule

// File: rtl/vliw_delay.sv
module vliw_delay
  import vliw_pkg::*;
#(
  parameter int LAT = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  flight_t din,
  output flight_t dout
);
  generate
    if (LAT <= 1) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      localparam int NSTG = LAT - 1;
      flight_t stg     [NSTG];
      flight_t stg_nxt [NSTG];

      always_comb begin
        stg_nxt[0] = din;
        for (int i = 1; i < NSTG; i++) stg_nxt[i] = stg[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < NSTG; i++) stg[i] <= '0;
        end else begin
          for (int i = 0; i < NSTG; i++) stg[i] <= stg_nxt[i];
        end
      end

      assign dout = stg[NSTG-1];
    end
  endgenerate
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile
  import vliw_pkg::*;
#(
  parameter int NRD = 2 * NSLOT,
  parameter int NWR = NSLOT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RAW-1:0]  ra [NRD],
  output logic [XLEN-1:0] rdat [NRD],
  input  logic            we [NWR],
  input  logic [RAW-1:0]  wa [NWR],
  input  logic [XLEN-1:0] wd [NWR],
  input  logic [RAW-1:0]  dbg_a,
  output logic [XLEN-1:0] dbg_d
);
  logic [XLEN-1:0] regs     [NREG];
  logic [XLEN-1:0] regs_nxt [NREG];

  always_comb begin
    regs_nxt = regs;
    for (int s = 0; s < NWR; s++) begin
      if (we[s] && (wa[s] != '0)) regs_nxt[wa[s]] = wd[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) regs[i] <= regs_nxt[i];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdat[p] = regs[ra[p]];
  end
  assign dbg_d = regs[dbg_a];
endmodule

// File: rtl/vliw_dmem.sv
module vliw_dmem
  import vliw_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MAW-1:0]  ra [NPORT],
  output logic [XLEN-1:0] rdat [NPORT],
  input  logic            we [NPORT],
  input  logic [MAW-1:0]  wa [NPORT],
  input  logic [XLEN-1:0] wd [NPORT]
);
  logic [XLEN-1:0] mem     [MEM_WORDS];
  logic [XLEN-1:0] mem_nxt [MEM_WORDS];

  always_comb begin
    mem_nxt = mem;
    for (int p = 0; p < NPORT; p++) begin
      if (we[p]) mem_nxt[wa[p]] = wd[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= mem_nxt[i];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign rdat[p] = mem[ra[p]];
  end
endmodule

// File: rtl/vliw_issue_core.sv
module vliw_issue_core
  import vliw_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bundle_valid,
  input  logic [NSLOT*SLOTW-1:0]   bundle,
  input  logic [RAW-1:0]           dbg_addr,
  output logic [XLEN-1:0]          dbg_data
);
  localparam int NRD  = 2 * NSLOT;
  localparam int MEM0 = 2;
  localparam int NMEM = 2;

  logic [RAW-1:0]  rf_ra   [NRD];
  logic [XLEN-1:0] rf_rd   [NRD];
  logic            rf_we   [NSLOT];
  logic [RAW-1:0]  rf_wa   [NSLOT];
  logic [XLEN-1:0] rf_wd   [NSLOT];
  logic [MAW-1:0]  dm_ra   [NMEM];
  logic [XLEN-1:0] dm_rd   [NMEM];
  logic            dm_we   [NMEM];
  logic [MAW-1:0]  dm_wa   [NMEM];
  logic [XLEN-1:0] dm_wd   [NMEM];
  flight_t         iss     [NSLOT];
  flight_t         fin     [NSLOT];
  logic [NSLOT-1:0] wb_en;
  logic [NMEM-1:0]  st_en;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int CLS = slot_class(s);
    localparam int LAT = slot_lat(s);
    logic [SLOTW-1:0] word;

    assign word          = bundle[s*SLOTW +: SLOTW];
    assign rf_ra[2*s]    = word[23:20];
    assign rf_ra[2*s+1]  = word[19:16];

    vliw_slot_exec #(.CLASS(CLS)) u_exec (
      .valid (bundle_valid),
      .word  (word),
      .a     (rf_rd[2*s]),
      .b     (rf_rd[2*s+1]),
      .res   (iss[s])
    );

    vliw_delay #(.LAT(LAT)) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (iss[s]),
      .dout (fin[s])
    );

    assign wb_en[s] = fin[s].wr;
    assign rf_we[s] = fin[s].wr;
    assign rf_wa[s] = fin[s].rd;
    if (CLS == CL_MEM) begin : g_mem
      assign rf_wd[s] = dm_rd[s-MEM0];
    end else begin : g_alu
      assign rf_wd[s] = fin[s].val;
    end
  end

  for (genvar m = 0; m < NMEM; m++) begin : g_mport
    assign dm_ra[m] = fin[MEM0+m].addr;
    assign dm_we[m] = fin[MEM0+m].st;
    assign dm_wa[m] = fin[MEM0+m].addr;
    assign dm_wd[m] = fin[MEM0+m].val;
    assign st_en[m] = fin[MEM0+m].st;
  end

  vliw_regfile #(.NRD(NRD), .NWR(NSLOT)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .ra   (rf_ra),
    .rdat (rf_rd),
    .we   (rf_we),
    .wa   (rf_wa),
    .wd   (rf_wd),
    .dbg_a(dbg_addr),
    .dbg_d(dbg_data)
  );

  vliw_dmem #(.NPORT(NMEM)) u_dm (
    .clk  (clk),
    .rst_n(rst_n),
    .ra   (dm_ra),
    .rdat (dm_rd),
    .we   (dm_we),
    .wa   (dm_wa),
    .wd   (dm_wd)
  );
endmodule

// File: rtl/vliw_issue_core_chk.sv
module vliw_issue_core_chk
  import vliw_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bundle_valid,
  input logic [OPW-1:0]  op0,
  input logic [OPW-1:0]  op2,
  input logic [OPW-1:0]  op4,
  input logic [RAW-1:0]  dbg_addr,
  input logic [XLEN-1:0] dbg_data,
  input logic [NSLOT-1:0] wb_en,
  input logic [1:0]      st_en
);
  // R2: a valid integer op in slot 0 retires in its issue cycle
  p_int_retire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle_valid && op0 >= OP_ADD && op0 <= OP_XOR) |-> wb_en[0]);

  // R3: a store in slot 2 reaches memory two edges after issue
  p_store_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle_valid && op2 == OP_ST) |-> ##2 st_en[0]);

  // R3: a load in slot 2 writes back two edges after issue
  p_load_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle_valid && op2 == OP_LD) |-> ##2 wb_en[2]);

  // R4: a floating-point add in slot 4 writes back three edges after issue
  p_fp_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle_valid && op4 == OP_FADD) |-> ##3 wb_en[4]);

  // R7: a NOP in slot 4 produces no write at its retire point
  p_fp_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle_valid && op4 == OP_NOP) |-> ##3 !wb_en[4]);

  // R8: register 0 never reads back non-zero
  p_zero_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == '0) |-> (dbg_data == '0));
endmodule

bind vliw_issue_core vliw_issue_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bundle_valid(bundle_valid),
  .op0         (bundle[31:28]),
  .op2         (bundle[95:92]),
  .op4         (bundle[159:156]),
  .dbg_addr    (dbg_addr),
  .dbg_data    (dbg_data),
  .wb_en       (wb_en),
  .st_en       (st_en)
);

// File: tb/vliw_issue_core_test.sv
module vliw_issue_core_test;
  logic         clk;
  logic         rst_n;
  logic         bundle_valid;
  logic [191:0] bundle;
  logic [3:0]   dbg_addr;
  logic [31:0]  dbg_data;
  int n_chk;
  int n_fail;

  vliw_issue_core uut (
    .clk(clk), .rst_n(rst_n), .bundle_valid(bundle_valid),
    .bundle(bundle), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [3:0] ADD = 1, SUB = 2, ADDI = 3, XOR = 4;
  localparam logic [3:0] LD = 1, ST = 2, FADD = 1;

  function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                      input logic [3:0] a, input logic [3:0] b,
                                      input logic [15:0] imm);
    return {op, rd, a, b, imm};
  endfunction

  function automatic logic [191:0] bnd(input logic [31:0] s0, input logic [31:0] s1,
                                       input logic [31:0] s2, input logic [31:0] s3,
                                       input logic [31:0] s4, input logic [31:0] s5);
    return {s5, s4, s3, s2, s1, s0};
  endfunction

  task automatic step(input logic v, input logic [191:0] b);
    bundle_valid = v;
    bundle       = b;
    @(negedge clk);
    bundle_valid = 1'b0;
    bundle       = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0);
  endtask

  task automatic chk(input logic [3:0] r, input logic [31:0] exp, input string tag);
    dbg_addr = r;
    #1;
    n_chk++;
    if (dbg_data !== exp) begin
      n_fail++;
      $display("FAIL %s: r%0d got %h expected %h", tag, r, dbg_data, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bundle_valid = 1'b0;
    bundle = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(4'd0, 32'h0, "R11 reset r0");
    chk(4'd5, 32'h0, "R11 reset r5");
    chk(4'd15, 32'h0, "R11 reset r15");
  endtask

  task automatic t_int();
    do_reset();
    step(1, bnd(enc(ADDI,1,0,0,16'd5), enc(ADDI,2,0,0,16'hFFFD), 0, 0, 0, 0));
    chk(4'd1, 32'd5, "R2 R1 R13 addi");
    chk(4'd2, 32'hFFFF_FFFD, "R2 addi negative");
    step(1, bnd(enc(ADD,3,1,2,0), enc(SUB,4,1,2,0), 0, 0, 0, 0));
    chk(4'd3, 32'd2, "R2 add");
    chk(4'd4, 32'd8, "R2 sub");
    step(1, bnd(0, enc(XOR,5,1,2,0), 0, 0, 0, 0));
    chk(4'd5, 32'hFFFF_FFF8, "R2 xor slot1");
  endtask

  task automatic t_intra();
    do_reset();
    step(1, bnd(enc(ADDI,1,0,0,16'd5), 0, 0, 0, 0, 0));
    step(1, bnd(enc(ADDI,1,0,0,16'd100), enc(ADD,6,1,0,0), 0, 0, enc(FADD,7,1,1,0), 0));
    chk(4'd1, 32'd100, "R5 producer");
    chk(4'd6, 32'd5, "R5 same-bundle int reads old");
    idle(3);
    chk(4'd7, 32'd10, "R5 same-bundle fp reads old");
  endtask

  task automatic t_mem();
    do_reset();
    step(1, bnd(enc(ADDI,7,0,0,16'h1234), 0, 0, 0, 0, 0));
    step(1, bnd(0, 0, enc(ST,0,0,7,16'd3), enc(LD,8,0,0,16'd3), 0, 0));
    idle(2);
    chk(4'd8, 32'h0, "R10 load sees pre-store word");
    step(1, bnd(0, 0, enc(LD,9,0,0,16'd3), 0, 0, 0));
    idle(1);
    chk(4'd9, 32'h0, "R3 load not yet retired");
    idle(1);
    chk(4'd9, 32'h1234, "R3 load after three cycles");
  endtask

  task automatic t_fp();
    do_reset();
    step(1, bnd(enc(ADDI,1,0,0,16'd7), enc(ADDI,2,0,0,16'd9), 0, 0, 0, 0));
    step(1, bnd(0, 0, 0, 0, enc(FADD,11,1,2,0), enc(FADD,12,1,1,0)));
    idle(2);
    chk(4'd11, 32'h0, "R4 fp stale at three");
    idle(1);
    chk(4'd11, 32'd16, "R4 fp slot4 at four");
    chk(4'd12, 32'd14, "R4 fp slot5 at four");
  endtask

  task automatic t_stale();
    do_reset();
    step(1, bnd(enc(ADDI,1,0,0,16'h55), 0, 0, 0, 0, 0));
    step(1, bnd(0, 0, 0, 0, enc(FADD,2,1,1,0), 0));
    step(1, bnd(enc(ADD,3,2,0,0), 0, 0, 0, 0, 0));
    step(1, bnd(enc(ADD,4,2,0,0), 0, 0, 0, 0, 0));
    step(1, bnd(enc(ADD,5,2,0,0), 0, 0, 0, 0, 0));
    step(1, bnd(enc(ADD,6,2,0,0), 0, 0, 0, 0, 0));
    chk(4'd3, 32'h0, "R6 stale read +1");
    chk(4'd5, 32'h0, "R6 stale read +3");
    chk(4'd6, 32'hAA, "R6 read after latency");
  endtask

  task automatic t_prio();
    do_reset();
    step(1, bnd(enc(ADDI,1,0,0,16'd1), enc(ADDI,1,0,0,16'd2), 0, 0, 0, 0));
    chk(4'd1, 32'd2, "R9 slot1 beats slot0");
    step(1, bnd(0, 0, 0, 0, enc(FADD,2,1,1,0), 0));
    idle(2);
    step(1, bnd(enc(ADDI,2,0,0,16'd7), 0, 0, 0, 0, 0));
    chk(4'd2, 32'd4, "R9 fp slot beats int in same cycle");
    step(1, bnd(0, 0, enc(ST,0,0,1,16'd5), enc(ST,0,0,2,16'd5), 0, 0));
    idle(2);
    step(1, bnd(0, 0, enc(LD,3,0,0,16'd5), 0, 0, 0));
    idle(2);
    chk(4'd3, 32'd4, "R9 slot3 store beats slot2");
  endtask

  task automatic t_nop();
    do_reset();
    step(1, bnd(enc(ADDI,3,0,0,16'h11), 0, 0, 0, 0, 0));
    step(1, bnd(enc(4'hF,3,0,0,16'd9), enc(4'h0,3,0,0,16'd9), enc(4'h7,3,0,0,16'd9),
                enc(4'h0,3,0,0,16'd9), enc(4'h9,3,0,0,16'd9), enc(4'h0,3,0,0,16'd9)));
    idle(4);
    chk(4'd3, 32'h11, "R7 nop and undefined opcodes");
    step(0, bnd(enc(ADDI,3,0,0,16'd99), 0, 0, 0, 0, 0));
    idle(4);
    chk(4'd3, 32'h11, "R12 invalid bundle ignored");
    step(1, bnd(enc(ADDI,0,0,0,16'd9), 0, 0, 0, 0, 0));
    chk(4'd0, 32'h0, "R8 r0 stays zero");
  endtask

  task automatic t_reset_flight();
    do_reset();
    step(1, bnd(enc(ADDI,1,0,0,16'h77), 0, 0, 0, 0, 0));
    step(1, bnd(0, 0, enc(ST,0,0,1,16'd2), 0, 0, 0));
    idle(2);
    step(1, bnd(0, 0, 0, 0, enc(FADD,15,1,1,0), 0));
    do_reset();
    idle(5);
    chk(4'd15, 32'h0, "R11 in-flight op dropped");
    chk(4'd1, 32'h0, "R11 register cleared");
    step(1, bnd(0, 0, enc(LD,4,0,0,16'd2), 0, 0, 0));
    idle(2);
    chk(4'd4, 32'h0, "R11 memory cleared");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    bundle_valid = 1'b0;
    bundle = '0;
    dbg_addr = '0;
    @(negedge clk);
    t_reset();
    t_int();
    t_intra();
    t_mem();
    t_fp();
    t_stale();
    t_prio();
    t_nop();
    t_reset_flight();
    report();
    $finish;
  end
endmodule